// File: doc/BRIEF.md
# Reloadable Down-Counter Frequency Divider

This block is one timer channel set up as a programmable frequency divider. Software writes a 16-bit period value and then fires a start strobe. On each tick of an externally supplied count-clock enable, a down-counter steps toward zero. Each time it reaches zero it reloads the period value, raises a one-cycle interrupt and flips the divided output. The output therefore has a period of 2 × (period + 1) count-clock ticks.

The first tick after a start does not count. It only copies the period value into the counter. A start-mode bit chooses whether that first load also fires the interrupt and flips the output. A stop strobe freezes both the counter and the output level where they are. Software can rewrite the period at any time, and the new value is used at the next reload. Software can also force the output level directly. When the output-enable bit is clear, the output-enable qualifier is low, so the pin is in high impedance, and the output keeps its level.

Top module: `freqdiv_channel`

## Requirements
- R1: After reset, `count_q`, `period_rd`, `enabled`, `irq`, `pin_out` and `pin_oe` are all 0.
- R2: A start strobe sets `enabled` on the following cycle. The first `cnt_tick` after that copies `period_rd` into `count_q` without decrementing.
- R3: With the start-mode bit at 1, the initial load pulses `irq` and flips `pin_out` (if output enable is 1). With the bit at 0, the initial load does neither.
- R4: While the channel runs, each `cnt_tick` with a non-zero count decrements `count_q` by 1. Cycles without `cnt_tick` leave it unchanged.
- R5: A `cnt_tick` that finds `count_q` at 0 reloads it from `period_rd`, pulses `irq` for exactly one clock, and flips `pin_out`. Interrupts are therefore spaced period+1 ticks apart.
- R6: A period write made while the channel runs is applied at the next reload, not before.
- R7: A stop strobe clears `enabled`. After it, `count_q` and `pin_out` stay frozen whatever `cnt_tick` does, and `count_q` stays readable.
- R8: A stop strobe in the same cycle as a start strobe wins, so `enabled` ends at 0. A start strobe while the channel runs restarts it with a fresh initial load.
- R9: `pin_out` flips only while the output-enable bit is 1, and `pin_oe` reflects that bit. A level write sets `pin_out` directly on the next cycle.
- R10: A write of the start-mode bit is ignored while `enabled` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| period_wr | input | 1 | Period register write strobe |
| period_wdata | input | 16 | Period value to write |
| mode_wr | input | 1 | Start-mode bit write strobe |
| mode_wdata | input | 1 | Start-mode value (1 = initial load fires interrupt and flips output) |
| oe_wr | input | 1 | Output-enable bit write strobe |
| oe_wdata | input | 1 | Output-enable value |
| lvl_wr | input | 1 | Output-level write strobe |
| lvl_wdata | input | 1 | Output level to force |
| start_trig | input | 1 | Start strobe, one cycle |
| stop_trig | input | 1 | Stop strobe, one cycle |
| count_q | output | 16 | Current counter value |
| period_rd | output | 16 | Period register readback |
| enabled | output | 1 | Channel running status |
| irq | output | 1 | One-cycle interrupt pulse |
| pin_out | output | 1 | Divided output level |
| pin_oe | output | 1 | Output drive enable (0 = high impedance) |

## Verification
The bench first attacks the initial load. A design that decrements on the first tick, or that ignores the start-mode bit, shows an interrupt or count off by one at the load. It then rewrites the period mid-run: a design that applies the value at once produces a shortened interval instead of a clean change at the next reload. Stop is exercised with ticks still arriving, and also together with a start in the same cycle. A design that resets the counter, keeps counting, or lets start win shows a moved count or a set `enabled`. Finally, a start-mode write while running and a run with output enable low catch a mode that changes mid-run and an output that flips while in high impedance.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned FDIV_CNT_W = 16;

  typedef enum logic [1:0] {
    FD_IDLE = 2'd0,
    FD_ARM  = 2'd1,
    FD_RUN  = 2'd2
  } fdiv_state_t;
endpackage

// File: rtl/fdiv_cfg_regs.sv
module fdiv_cfg_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         running,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  input  logic         mode_wr,
  input  logic         mode_wdata,
  input  logic         oe_wr,
  input  logic         oe_wdata,
  output logic [W-1:0] period_q,
  output logic         mode_q,
  output logic         oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      mode_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (period_wr)
        period_q <= period_wdata;
      // mode is frozen while the channel runs
      if (mode_wr && !running)
        mode_q <= mode_wdata;
      if (oe_wr)
        oe_q <= oe_wdata;
    end
  end
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter
  import fdiv_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_tick,
  input  logic         start_trig,
  input  logic         stop_trig,
  input  logic [W-1:0] period_q,
  input  logic         mode_q,
  output logic [W-1:0] count_q,
  output logic         running,
  output logic         arm,
  output logic         evt
);
  localparam logic [W-1:0] ZERO = '0;

  fdiv_state_t st;
  logic        ctl_free;
  logic        at_zero;

  assign ctl_free = !stop_trig && !start_trig;
  assign at_zero  = (count_q == ZERO);
  assign running  = (st != FD_IDLE);
  assign arm      = (st == FD_ARM);

  always_comb begin
    evt = 1'b0;
    if (ctl_free && cnt_tick) begin
      unique case (st)
        FD_ARM:  evt = mode_q;
        FD_RUN:  evt = at_zero;
        default: evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FD_IDLE;
      count_q <= '0;
    end else if (stop_trig) begin
      st <= FD_IDLE;
    end else if (start_trig) begin
      st <= FD_ARM;
    end else if (cnt_tick) begin
      unique case (st)
        FD_ARM: begin
          count_q <= period_q;
          st      <= FD_RUN;
        end
        FD_RUN: begin
          if (at_zero)
            count_q <= period_q;
          else
            count_q <= count_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fdiv_out_stage.sv
module fdiv_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic oe_q,
  input  logic lvl_wr,
  input  logic lvl_wdata,
  output logic irq,
  output logic pin_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      irq <= evt;
      if (lvl_wr)
        pin_out <= lvl_wdata;
      else if (evt && oe_q)
        pin_out <= ~pin_out;
    end
  end
endmodule

// File: rtl/freqdiv_channel.sv
module freqdiv_channel #(
  parameter int unsigned W = fdiv_pkg::FDIV_CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_tick,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  input  logic         mode_wr,
  input  logic         mode_wdata,
  input  logic         oe_wr,
  input  logic         oe_wdata,
  input  logic         lvl_wr,
  input  logic         lvl_wdata,
  input  logic         start_trig,
  input  logic         stop_trig,
  output logic [W-1:0] count_q,
  output logic [W-1:0] period_rd,
  output logic         enabled,
  output logic         irq,
  output logic         pin_out,
  output logic         pin_oe
);
  logic mode_q;
  logic oe_q;
  logic running;
  logic arm_pending;
  logic evt;

  fdiv_cfg_regs #(.W(W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .running      (running),
    .period_wr    (period_wr),
    .period_wdata (period_wdata),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .oe_wr        (oe_wr),
    .oe_wdata     (oe_wdata),
    .period_q     (period_rd),
    .mode_q       (mode_q),
    .oe_q         (oe_q)
  );

  fdiv_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cnt_tick   (cnt_tick),
    .start_trig (start_trig),
    .stop_trig  (stop_trig),
    .period_q   (period_rd),
    .mode_q     (mode_q),
    .count_q    (count_q),
    .running    (running),
    .arm        (arm_pending),
    .evt        (evt)
  );

  fdiv_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .oe_q      (oe_q),
    .lvl_wr    (lvl_wr),
    .lvl_wdata (lvl_wdata),
    .irq       (irq),
    .pin_out   (pin_out)
  );

  assign enabled = running;
  assign pin_oe  = oe_q;
endmodule

// File: rtl/fdiv_channel_chk.sv
module fdiv_channel_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_tick,
  input logic         start_trig,
  input logic         stop_trig,
  input logic         lvl_wr,
  input logic [W-1:0] count_q,
  input logic [W-1:0] period_rd,
  input logic         enabled,
  input logic         arm_pending,
  input logic         irq,
  input logic         pin_out,
  input logic         pin_oe
);
  localparam logic [W-1:0] ZERO = '0;

  p_stop_priority_r8: assert property (@(posedge clk) disable iff (rst)
    (start_trig && stop_trig) |=> !enabled);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (start_trig && !stop_trig) |=> (enabled && arm_pending));

  p_initial_load_r2: assert property (@(posedge clk) disable iff (rst)
    (arm_pending && cnt_tick && !start_trig && !stop_trig)
      |=> (count_q == $past(period_rd) && !arm_pending));

  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (enabled && !arm_pending && cnt_tick && count_q != ZERO && !start_trig && !stop_trig)
      |=> (count_q == $past(count_q) - 1'b1));

  p_reload_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (enabled && !arm_pending && cnt_tick && count_q == ZERO && !start_trig && !stop_trig)
      |=> (irq && count_q == $past(period_rd)));

  p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(cnt_tick) && $past(enabled)));

  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !start_trig) |=> $stable(count_q));

  p_hiz_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!pin_oe && !lvl_wr) |=> $stable(pin_out));
endmodule

bind freqdiv_channel fdiv_channel_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_tick    (cnt_tick),
  .start_trig  (start_trig),
  .stop_trig   (stop_trig),
  .lvl_wr      (lvl_wr),
  .count_q     (count_q),
  .period_rd   (period_rd),
  .enabled     (enabled),
  .arm_pending (arm_pending),
  .irq         (irq),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe)
);

// File: tb/freqdiv_channel_test.sv
module freqdiv_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_tick = 1'b0;
  logic         period_wr = 1'b0;
  logic [W-1:0] period_wdata = '0;
  logic         mode_wr = 1'b0, mode_wdata = 1'b0;
  logic         oe_wr = 1'b0, oe_wdata = 1'b0;
  logic         lvl_wr = 1'b0, lvl_wdata = 1'b0;
  logic         start_trig = 1'b0, stop_trig = 1'b0;
  logic [W-1:0] count_q, period_rd;
  logic         enabled, irq, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_cnt = 0, m_per = 0;
  bit m_en = 0, m_first = 0, m_mode = 0, m_oe = 0, m_lvl = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freqdiv_channel #(.W(W)) uut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick),
    .period_wr(period_wr), .period_wdata(period_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .oe_wr(oe_wr), .oe_wdata(oe_wdata),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .start_trig(start_trig), .stop_trig(stop_trig),
    .count_q(count_q), .period_rd(period_rd), .enabled(enabled),
    .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always @(posedge clk) begin
    bit fire;
    fire = 0;
    if (rst) begin
      m_cnt = 0; m_per = 0; m_en = 0; m_first = 0;
      m_mode = 0; m_oe = 0; m_lvl = 0; m_irq = 0;
    end else begin
      if (stop_trig) begin
        m_en = 0; m_first = 0;
      end else if (start_trig) begin
        m_en = 1; m_first = 1;
      end else if (m_en && cnt_tick) begin
        if (m_first) begin
          m_cnt = m_per; m_first = 0; fire = m_mode;
        end else if (m_cnt == 0) begin
          m_cnt = m_per; fire = 1;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      m_irq = fire;
      if (lvl_wr) m_lvl = lvl_wdata;
      else if (fire && m_oe) m_lvl = !m_lvl;
      if (mode_wr && !(m_en_prev_hold())) m_mode = mode_wdata;
      if (oe_wr) m_oe = oe_wdata;
      if (period_wr) m_per = int'(period_wdata);
    end
    en_hold = m_en;
  end

  // enable value seen before this edge, for the mode-write gate
  bit en_hold = 0;
  function automatic bit m_en_prev_hold();
    return en_hold;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    chk("R4 count", int'(count_q), m_cnt);
    chk("R2 enabled", int'(enabled), int'(m_en));
    chk("R5 irq", int'(irq), int'(m_irq));
    chk("R9 pin_out", int'(pin_out), int'(m_lvl));
    chk("R9 pin_oe", int'(pin_oe), int'(m_oe));
    chk("R6 period", int'(period_rd), m_per);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap;
    int last;
    int held_cnt;
    bit held_lvl;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 count", int'(count_q), 0);
    chk("R1 enabled", int'(enabled), 0);
    chk("R1 irq/pin", int'({irq, pin_out, pin_oe}), 0);

    // configure: period 3, mode 1, oe 1
    period_wr = 1; period_wdata = 16'd3; mode_wr = 1; mode_wdata = 1; oe_wr = 1; oe_wdata = 1;
    cyc();
    period_wr = 0; mode_wr = 0; oe_wr = 0;
    start_trig = 1;
    cyc();
    start_trig = 0;
    cnt_tick = 1;
    chk("R2 enabled after start", int'(enabled), 1);
    cyc();
    chk("R2 initial load", int'(count_q), 3);
    chk("R3 mode1 irq", int'(irq), 1);
    chk("R3 mode1 toggle", int'(pin_out), 1);
    // R5 spacing between interrupts
    last = 0;
    for (int i = 1; i <= 12; i++) begin
      cyc();
      if (irq) begin
        gap = i - last;
        chk("R5 irq spacing", gap, 4);
        last = i;
      end
    end

    // R6 period rewrite while running
    period_wr = 1; period_wdata = 16'd1;
    cyc();
    period_wr = 0;
    for (int i = 0; i < 8 && !irq; i++) cyc();
    chk("R6 new period at reload", int'(count_q), 1);

    // R4 no ticks -> hold
    cnt_tick = 0;
    held_cnt = int'(count_q);
    repeat (3) cyc();
    chk("R4 hold without tick", int'(count_q), held_cnt);
    cnt_tick = 1;
    repeat (2) cyc();

    // R7 stop freezes
    stop_trig = 1;
    cyc();
    stop_trig = 0;
    held_cnt = int'(count_q);
    held_lvl = pin_out;
    repeat (5) cyc();
    chk("R7 enabled cleared", int'(enabled), 0);
    chk("R7 count frozen", int'(count_q), held_cnt);
    chk("R7 level frozen", int'(pin_out), int'(held_lvl));

    // R3 mode 0 initial load
    mode_wr = 1; mode_wdata = 0; period_wr = 1; period_wdata = 16'd2;
    cyc();
    mode_wr = 0; period_wr = 0;
    start_trig = 1;
    cyc();
    start_trig = 0;
    held_lvl = pin_out;
    cyc();
    chk("R3 mode0 load count", int'(count_q), 2);
    chk("R3 mode0 no irq", int'(irq), 0);
    chk("R3 mode0 no toggle", int'(pin_out), int'(held_lvl));

    // R10 mode write while running ignored
    mode_wr = 1; mode_wdata = 1;
    cyc();
    mode_wr = 0;
    stop_trig = 1;
    cyc();
    stop_trig = 0;
    start_trig = 1;
    cyc();
    start_trig = 0;
    cyc();
    chk("R10 mode unchanged, no irq at load", int'(irq), 0);

    // R8 start while running restarts
    repeat (1) cyc();
    start_trig = 1;
    cyc();
    start_trig = 0;
    chk("R8 restart arms", int'(enabled), 1);
    cyc();
    chk("R8 fresh load", int'(count_q), 2);
    // R8 simultaneous start and stop
    start_trig = 1; stop_trig = 1;
    cyc();
    start_trig = 0; stop_trig = 0;
    chk("R8 stop wins", int'(enabled), 0);

    // R9 output disabled: no toggle, level write works
    oe_wr = 1; oe_wdata = 0;
    cyc();
    oe_wr = 0;
    chk("R9 pin_oe low", int'(pin_oe), 0);
    held_lvl = pin_out;
    start_trig = 1;
    cyc();
    start_trig = 0;
    for (int i = 0; i < 10; i++) cyc();
    chk("R9 no toggle when disabled", int'(pin_out), int'(held_lvl));
    lvl_wr = 1; lvl_wdata = !held_lvl;
    cyc();
    lvl_wr = 0;
    chk("R9 level write", int'(pin_out), int'(!held_lvl));
    repeat (3) cyc();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule